// File: doc/BRIEF.md
# Extended Capability List Walker

The walker locates a capability in the extended region of a 4 KB configuration space by following the chain of 32-bit headers that the capabilities form. Each header carries a capability ID in bits 15:0, a version in bits 19:16 (never inspected) and the byte offset of the next header in bits 31:20. A search starts at byte offset 256 and issues one word read per visited header. The configuration memory has one-cycle read latency. The search ends with the offset of the matching header and the offset of the header before it.

An ID of zero never matches anything, so a search for zero runs to the end of the chain. It then reports the last header as the predecessor, which is where software appends a new capability. A second request channel patches the next field of a chosen header by read-modify-write. The ID and version bits of that header are kept.

Only one operation is in flight at a time. A request that arrives while either operation is active is dropped.

Top module: `ecap_list_walker`

## Requirements
- R1: After reset, res_done_o, res_err_o, lnk_done_o, lnk_err_o, busy_o, mem_rd_en_o and mem_wr_en_o are all low.
- R2: A search reads the header at offset 256 first and then follows bits 31:20 of each header. It returns in res_off_o the offset of the first header whose bits 15:0 equal the requested ID. res_prev_o holds the offset of the header visited before it, or 0 when the first header matched. Bits 19:16 do not affect the result.
- R3: If the word at offset 256 is all zeros, the search ends after that one read with res_off_o = 0, res_prev_o = 0 and no error.
- R4: If no header matches, the search stops at the first header whose next field is 0. It returns res_off_o = 0 with res_prev_o equal to that header's offset and no error.
- R5: A requested ID of 0 matches no header, even one whose ID field is 0. The search therefore returns res_off_o = 0 and the tail header's offset in res_prev_o.
- R6: A next pointer below 256 or above 4088 ends the search with res_err_o. res_off_o then holds the bad pointer and res_prev_o the header that held it. No read is ever issued outside 256..4088.
- R7: When MAX_HOPS headers have been read without reaching an end, the search stops with res_err_o. res_off_o then holds the pointer that would have been followed next and res_prev_o the last header read.
- R8: The search issues exactly one read per visited header. res_done_o is a one-cycle pulse that rises 2N+1 clock edges after the edge that accepts the request, where N is the number of headers read.
- R9: A link request (lnk_pos_i, lnk_next_i) reads the word at lnk_pos_i and writes it back. Bits 31:20 are replaced by lnk_next_i and bits 19:0 are kept. lnk_done_o pulses two edges after acceptance, in the same cycle as the write.
- R10: A link request whose new next offset is not a multiple of 4, or whose target offset is unaligned or outside 256..4088, pulses lnk_done_o with lnk_err_o one edge after acceptance. It writes nothing.
- R11: Requests that arrive while busy_o is high are ignored. When a search and a link request arrive in the same cycle, the search runs and the link request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a search (single-cycle strobe) |
| req_id_i | input | 16 | Capability ID to search for |
| lnk_valid_i | input | 1 | Start a next-pointer patch |
| lnk_pos_i | input | 12 | Byte offset of the header to patch |
| lnk_next_i | input | 12 | New next offset |
| busy_o | output | 1 | An operation is in flight |
| mem_rd_en_o | output | 1 | Configuration memory read strobe |
| mem_rd_addr_o | output | 10 | Word address of the read |
| mem_rd_data_i | input | 32 | Read data, valid the cycle after the strobe |
| mem_wr_en_o | output | 1 | Configuration memory write strobe |
| mem_wr_addr_o | output | 10 | Word address of the write |
| mem_wr_data_o | output | 32 | Write data |
| res_done_o | output | 1 | Search finished (pulse) |
| res_err_o | output | 1 | Search ended on a range or hop-limit error |
| res_off_o | output | 12 | Matched offset, or 0, or the offending pointer |
| res_prev_o | output | 12 | Offset of the predecessor header |
| lnk_done_o | output | 1 | Patch finished (pulse) |
| lnk_err_o | output | 1 | Patch rejected |

## Verification
The bench keeps the 4 KB space and the base of 256, so pointers of 0x080 and 0xFFC hit the lower and upper range edges. MAX_HOPS is lowered to 16, so a three-header loop trips the cycle guard after 16 reads, 33 edges after acceptance. The default of 1024 would take about two thousand cycles for the same check. Every search result is compared against its expected offset, predecessor, error flag and exact latency. Together these pin down both the pointer chasing and the one-read-per-hop timing.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int ID_W  = 16;
  localparam int HDR_W = 32;

  typedef struct packed {
    logic [11:0] nxt;
    logic [3:0]  ver;
    logic [15:0] id;
  } ecap_hdr_t;

  typedef enum logic [2:0] {
    W_IDLE, W_READ, W_CHECK, W_DONE, W_ERR
  } walk_st_e;

  typedef enum logic [1:0] {
    L_IDLE, L_RD, L_WR, L_ERR
  } lnk_st_e;
endpackage

// File: rtl/ecap_hdr_check.sv
module ecap_hdr_check
  import ecap_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int BASE_OFF  = 256,
  parameter int LIMIT_OFF = 4088
) (
  input  logic [HDR_W-1:0] hdr_i,
  input  logic [ID_W-1:0]  id_i,
  output logic             id_hit_o,
  output logic             all_zero_o,
  output logic             end_o,
  output logic [OFF_W-1:0] next_off_o,
  output logic             next_bad_o
);
  localparam logic [OFF_W-1:0] BASE_L  = OFF_W'(BASE_OFF);
  localparam logic [OFF_W-1:0] LIMIT_L = OFF_W'(LIMIT_OFF);

  ecap_hdr_t hdr;
  assign hdr = ecap_hdr_t'(hdr_i);

  // ID 0 is reserved: it never hits, so a search for it runs to the tail
  assign id_hit_o   = (id_i != '0) && (hdr.id == id_i);
  assign all_zero_o = (hdr_i == '0);
  assign end_o      = (hdr.nxt == '0);
  assign next_off_o = OFF_W'(hdr.nxt);
  assign next_bad_o = (next_off_o < BASE_L) || (next_off_o > LIMIT_L);
endmodule

// File: rtl/ecap_walk_fsm.sv
module ecap_walk_fsm
  import ecap_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int BASE_OFF  = 256,
  parameter int LIMIT_OFF = 4088,
  parameter int MAX_HOPS  = 1024,
  localparam int WADDR_W  = OFF_W - 2,
  localparam int HOP_W    = $clog2(MAX_HOPS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ID_W-1:0]    id_i,
  output logic               busy_o,
  output logic               rd_en_o,
  output logic [WADDR_W-1:0] rd_addr_o,
  input  logic [HDR_W-1:0]   rd_data_i,
  output logic               done_o,
  output logic               err_o,
  output logic [OFF_W-1:0]   off_o,
  output logic [OFF_W-1:0]   prev_o
);
  localparam logic [OFF_W-1:0] BASE_L  = OFF_W'(BASE_OFF);
  localparam logic [OFF_W-1:0] LIMIT_L = OFF_W'(LIMIT_OFF);
  localparam logic [HOP_W-1:0] HOPS_L  = HOP_W'(MAX_HOPS);

  walk_st_e         st_q;
  logic [ID_W-1:0]  id_q;
  logic [OFF_W-1:0] cur_q, prev_q, off_q, rprev_q;
  logic [HOP_W-1:0] hops_q;

  logic             id_hit, all_zero, at_end, next_bad;
  logic [OFF_W-1:0] next_off;

  ecap_hdr_check #(
    .OFF_W(OFF_W), .BASE_OFF(BASE_OFF), .LIMIT_OFF(LIMIT_OFF)
  ) u_hdr (
    .hdr_i      (rd_data_i),
    .id_i       (id_q),
    .id_hit_o   (id_hit),
    .all_zero_o (all_zero),
    .end_o      (at_end),
    .next_off_o (next_off),
    .next_bad_o (next_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= W_IDLE;
      id_q    <= '0;
      cur_q   <= '0;
      prev_q  <= '0;
      off_q   <= '0;
      rprev_q <= '0;
      hops_q  <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          id_q   <= id_i;
          cur_q  <= BASE_L;
          prev_q <= '0;
          hops_q <= '0;
          st_q   <= W_READ;
        end
        W_READ: begin
          hops_q <= hops_q + 1'b1;
          st_q   <= W_CHECK;
        end
        W_CHECK: begin
          if (hops_q == HOP_W'(1) && all_zero) begin
            off_q   <= '0;
            rprev_q <= '0;
            st_q    <= W_DONE;
          end else if (id_hit) begin
            off_q   <= cur_q;
            rprev_q <= prev_q;
            st_q    <= W_DONE;
          end else if (at_end) begin
            off_q   <= '0;
            rprev_q <= cur_q;
            st_q    <= W_DONE;
          end else if (next_bad || hops_q == HOPS_L) begin
            off_q   <= next_off;
            rprev_q <= cur_q;
            st_q    <= W_ERR;
          end else begin
            prev_q <= cur_q;
            cur_q  <= next_off;
            st_q   <= W_READ;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != W_IDLE);
  assign rd_en_o   = (st_q == W_READ);
  assign rd_addr_o = cur_q[OFF_W-1:2];
  assign done_o    = (st_q == W_DONE) || (st_q == W_ERR);
  assign err_o     = (st_q == W_ERR);
  assign off_o     = off_q;
  assign prev_o    = rprev_q;

  p_rd_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> ({rd_addr_o, 2'b00} >= BASE_L) && ({rd_addr_o, 2'b00} <= LIMIT_L));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_read_then_check_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
  p_hop_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hops_q <= HOPS_L);
  p_prev_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (prev_o == '0 || prev_o >= BASE_L));
endmodule

// File: rtl/ecap_link_patch.sv
module ecap_link_patch
  import ecap_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int BASE_OFF  = 256,
  parameter int LIMIT_OFF = 4088,
  localparam int WADDR_W  = OFF_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [OFF_W-1:0]   pos_i,
  input  logic [OFF_W-1:0]   next_i,
  output logic               busy_o,
  output logic               rd_en_o,
  output logic [WADDR_W-1:0] rd_addr_o,
  input  logic [HDR_W-1:0]   rd_data_i,
  output logic               wr_en_o,
  output logic [WADDR_W-1:0] wr_addr_o,
  output logic [HDR_W-1:0]   wr_data_o,
  output logic               done_o,
  output logic               err_o
);
  localparam logic [OFF_W-1:0] BASE_L  = OFF_W'(BASE_OFF);
  localparam logic [OFF_W-1:0] LIMIT_L = OFF_W'(LIMIT_OFF);

  lnk_st_e          st_q;
  logic [OFF_W-1:0] pos_q, next_q;
  logic             bad_req;
  ecap_hdr_t        old_hdr, new_hdr;

  assign bad_req = (next_i[1:0] != 2'b00) || (pos_i[1:0] != 2'b00) ||
                   (pos_i < BASE_L) || (pos_i > LIMIT_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= L_IDLE;
      pos_q  <= '0;
      next_q <= '0;
    end else begin
      unique case (st_q)
        L_IDLE: if (start_i) begin
          pos_q  <= pos_i;
          next_q <= next_i;
          st_q   <= bad_req ? L_ERR : L_RD;
        end
        L_RD:    st_q <= L_WR;
        default: st_q <= L_IDLE;
      endcase
    end
  end

  always_comb begin
    old_hdr     = ecap_hdr_t'(rd_data_i);
    new_hdr     = old_hdr;
    new_hdr.nxt = 12'(next_q);
  end

  assign busy_o    = (st_q != L_IDLE);
  assign rd_en_o   = (st_q == L_RD);
  assign rd_addr_o = pos_q[OFF_W-1:2];
  assign wr_en_o   = (st_q == L_WR);
  assign wr_addr_o = pos_q[OFF_W-1:2];
  assign wr_data_o = new_hdr;
  assign done_o    = (st_q == L_WR) || (st_q == L_ERR);
  assign err_o     = (st_q == L_ERR);

  p_rmw_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rd_en_o) && ($past(rd_addr_o) == wr_addr_o));
  p_aligned_next_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_data_o[21:20] == 2'b00));
  p_keep_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_data_o[19:0] == rd_data_i[19:0]));
endmodule

// File: rtl/ecap_list_walker.sv
module ecap_list_walker
  import ecap_pkg::*;
#(
  parameter int CFG_BYTES     = 4096,
  parameter int BASE_OFF      = 256,
  parameter int MIN_CAP_BYTES = 8,
  parameter int MAX_HOPS      = 1024,
  localparam int OFF_W        = $clog2(CFG_BYTES),
  localparam int WADDR_W      = OFF_W - 2,
  localparam int LIMIT_OFF    = CFG_BYTES - MIN_CAP_BYTES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ID_W-1:0]    req_id_i,
  input  logic               lnk_valid_i,
  input  logic [OFF_W-1:0]   lnk_pos_i,
  input  logic [OFF_W-1:0]   lnk_next_i,
  output logic               busy_o,
  output logic               mem_rd_en_o,
  output logic [WADDR_W-1:0] mem_rd_addr_o,
  input  logic [HDR_W-1:0]   mem_rd_data_i,
  output logic               mem_wr_en_o,
  output logic [WADDR_W-1:0] mem_wr_addr_o,
  output logic [HDR_W-1:0]   mem_wr_data_o,
  output logic               res_done_o,
  output logic               res_err_o,
  output logic [OFF_W-1:0]   res_off_o,
  output logic [OFF_W-1:0]   res_prev_o,
  output logic               lnk_done_o,
  output logic               lnk_err_o
);
  logic               w_busy, l_busy, idle_all;
  logic               w_start, l_start;
  logic               w_rd, l_rd;
  logic [WADDR_W-1:0] w_addr, l_addr;

  assign idle_all = !w_busy && !l_busy;
  assign w_start  = req_valid_i && idle_all;
  assign l_start  = lnk_valid_i && idle_all && !req_valid_i;

  ecap_walk_fsm #(
    .OFF_W(OFF_W), .BASE_OFF(BASE_OFF), .LIMIT_OFF(LIMIT_OFF), .MAX_HOPS(MAX_HOPS)
  ) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (w_start),
    .id_i      (req_id_i),
    .busy_o    (w_busy),
    .rd_en_o   (w_rd),
    .rd_addr_o (w_addr),
    .rd_data_i (mem_rd_data_i),
    .done_o    (res_done_o),
    .err_o     (res_err_o),
    .off_o     (res_off_o),
    .prev_o    (res_prev_o)
  );

  ecap_link_patch #(
    .OFF_W(OFF_W), .BASE_OFF(BASE_OFF), .LIMIT_OFF(LIMIT_OFF)
  ) u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (l_start),
    .pos_i     (lnk_pos_i),
    .next_i    (lnk_next_i),
    .busy_o    (l_busy),
    .rd_en_o   (l_rd),
    .rd_addr_o (l_addr),
    .rd_data_i (mem_rd_data_i),
    .wr_en_o   (mem_wr_en_o),
    .wr_addr_o (mem_wr_addr_o),
    .wr_data_o (mem_wr_data_o),
    .done_o    (lnk_done_o),
    .err_o     (lnk_err_o)
  );

  assign busy_o        = !idle_all;
  assign mem_rd_en_o   = w_rd || l_rd;
  assign mem_rd_addr_o = w_rd ? w_addr : l_addr;

  p_one_owner_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_busy && l_busy));
  p_rd_exclusive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_rd && l_rd));
  p_no_write_in_walk_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_busy |-> !mem_wr_en_o);
endmodule

// File: tb/ecap_list_walker_tb.sv
module ecap_list_walker_tb;
  localparam int OFF_W   = 12;
  localparam int WADDR_W = 10;
  localparam int HOPS    = 16;

  typedef struct {
    logic [11:0] off;
    logic [11:0] prev;
    logic        err;
    int          lat;
    int          t0;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic               req_valid = 1'b0;
  logic [15:0]        req_id = '0;
  logic               lnk_valid = 1'b0;
  logic [OFF_W-1:0]   lnk_pos = '0, lnk_next = '0;
  logic               busy, rd_en, wr_en;
  logic [WADDR_W-1:0] rd_addr, wr_addr;
  logic [31:0]        rd_data, wr_data;
  logic               res_done, res_err, lnk_done, lnk_err;
  logic [OFF_W-1:0]   res_off, res_prev;

  ecap_list_walker #(.MAX_HOPS(HOPS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_id_i(req_id),
    .lnk_valid_i(lnk_valid), .lnk_pos_i(lnk_pos), .lnk_next_i(lnk_next),
    .busy_o(busy),
    .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
    .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .res_done_o(res_done), .res_err_o(res_err),
    .res_off_o(res_off), .res_prev_o(res_prev),
    .lnk_done_o(lnk_done), .lnk_err_o(lnk_err)
  );

  logic [31:0] mem [1024];
  always @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  exp_t sb[$];
  int lnk_cnt = 0, lnk_lat = 0, lnk_t0 = 0;
  logic lnk_err_seen = 1'b0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] v, input logic [11:0] n);
    return {n, v, id};
  endfunction

  // Monitor: pop expected result on every completion
  always @(negedge clk) begin
    if (rst_n && res_done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11 unexpected result", 32'(res_off), 32'hFFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_off == e.off, {e.tag, " off"}, 32'(res_off), 32'(e.off));
        check(res_prev == e.prev, {e.tag, " prev"}, 32'(res_prev), 32'(e.prev));
        check(res_err == e.err, {e.tag, " err"}, 32'(res_err), 32'(e.err));
        check((cyc - e.t0) == e.lat, "R8 latency", 32'(cyc - e.t0), 32'(e.lat));
      end
    end
    if (rst_n && lnk_done) begin
      lnk_cnt++;
      lnk_lat = cyc - lnk_t0;
      lnk_err_seen = lnk_err;
    end
  end

  task automatic settle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic walk(input logic [15:0] id, input logic [11:0] off, input logic [11:0] prev,
                      input logic err, input int reads, input string tag);
    exp_t e;
    @(negedge clk);
    e.off = off; e.prev = prev; e.err = err; e.lat = 2 * reads + 1; e.t0 = cyc; e.tag = tag;
    sb.push_back(e);
    req_id = id;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    settle();
  endtask

  task automatic link(input logic [11:0] pos, input logic [11:0] nxt, input logic err, input string tag);
    int c0;
    @(negedge clk);
    c0 = lnk_cnt;
    lnk_t0 = cyc;
    lnk_pos = pos; lnk_next = nxt;
    lnk_valid = 1'b1;
    @(negedge clk);
    lnk_valid = 1'b0;
    settle();
    check(lnk_cnt == c0 + 1, {tag, " done count"}, 32'(lnk_cnt), 32'(c0 + 1));
    check(lnk_err_seen == err, {tag, " err"}, 32'(lnk_err_seen), 32'(err));
    check(lnk_lat == (err ? 1 : 2), {tag, " latency"}, 32'(lnk_lat), err ? 32'd1 : 32'd2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!res_done && !res_err && !lnk_done && !lnk_err, "R1 done/err", 32'(res_done), 0);
    check(!busy && !rd_en && !wr_en, "R1 busy/mem", 32'({busy, rd_en, wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    walk(16'h0001, 12'h000, 12'h000, 1'b0, 1, "R3 empty list");

    mem[12'h100 >> 2] = hdr(16'h0003, 4'h1, 12'h140);
    mem[12'h140 >> 2] = hdr(16'h000E, 4'h2, 12'h300);
    mem[12'h300 >> 2] = hdr(16'h0010, 4'h1, 12'h000);
    walk(16'h0003, 12'h100, 12'h000, 1'b0, 1, "R2 first entry");
    walk(16'h000E, 12'h140, 12'h100, 1'b0, 2, "R2 second entry");
    walk(16'h0010, 12'h300, 12'h140, 1'b0, 3, "R2 third entry");
    walk(16'h0055, 12'h000, 12'h300, 1'b0, 3, "R4 no match");
    walk(16'h0000, 12'h000, 12'h300, 1'b0, 3, "R5 find tail");

    // R9: append a header after the tail
    mem[12'h400 >> 2] = hdr(16'h0000, 4'h3, 12'h000);
    link(12'h300, 12'h400, 1'b0, "R9 patch");
    check(mem[12'h300 >> 2] == hdr(16'h0010, 4'h1, 12'h400), "R9 patched word",
          mem[12'h300 >> 2], hdr(16'h0010, 4'h1, 12'h400));
    walk(16'h0000, 12'h000, 12'h400, 1'b0, 4, "R5 zero-ID entry skipped");

    // R10: rejected patches leave memory untouched
    link(12'h300, 12'h402, 1'b1, "R10 unaligned next");
    check(mem[12'h300 >> 2] == hdr(16'h0010, 4'h1, 12'h400), "R10 word kept",
          mem[12'h300 >> 2], hdr(16'h0010, 4'h1, 12'h400));
    link(12'h0F0, 12'h400, 1'b1, "R10 target below base");
    check(mem[12'h0F0 >> 2] == 32'h0, "R10 low word kept", mem[12'h0F0 >> 2], 0);

    // R6: range errors at both edges
    mem[12'h400 >> 2] = hdr(16'h0020, 4'h1, 12'h080);
    walk(16'h0077, 12'h080, 12'h400, 1'b1, 4, "R6 pointer below base");
    mem[12'h400 >> 2] = hdr(16'h0020, 4'h1, 12'hFFC);
    walk(16'h0077, 12'hFFC, 12'h400, 1'b1, 4, "R6 pointer above limit");

    // R7: loop 0x140 -> 0x300 -> 0x400 -> 0x140; the 16th read is at 0x400
    mem[12'h400 >> 2] = hdr(16'h0020, 4'h1, 12'h140);
    walk(16'h0077, 12'h140, 12'h400, 1'b1, HOPS, "R7 hop guard");

    // R11: requests while busy are ignored
    mem[12'h400 >> 2] = hdr(16'h0020, 4'h1, 12'h000);
    begin
      exp_t e;
      int c0;
      c0 = lnk_cnt;
      @(negedge clk);
      e.off = 12'h000; e.prev = 12'h400; e.err = 1'b0; e.lat = 9; e.t0 = cyc; e.tag = "R11 busy walk";
      sb.push_back(e);
      req_id = 16'h0077; req_valid = 1'b1;
      @(negedge clk);
      req_id = 16'h0003;
      lnk_pos = 12'h300; lnk_next = 12'h500; lnk_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; lnk_valid = 1'b0;
      settle();
      check(lnk_cnt == c0, "R11 link while busy", 32'(lnk_cnt), 32'(c0));
      check(mem[12'h300 >> 2] == hdr(16'h0010, 4'h1, 12'h400), "R11 word kept",
            mem[12'h300 >> 2], hdr(16'h0010, 4'h1, 12'h400));
      // simultaneous requests: search wins
      @(negedge clk);
      e.off = 12'h140; e.prev = 12'h100; e.err = 1'b0; e.lat = 5; e.t0 = cyc; e.tag = "R11 same-cycle walk";
      sb.push_back(e);
      req_id = 16'h000E; req_valid = 1'b1;
      lnk_pos = 12'h300; lnk_next = 12'h500; lnk_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; lnk_valid = 1'b0;
      settle();
      check(lnk_cnt == c0, "R11 same-cycle link dropped", 32'(lnk_cnt), 32'(c0));
    end

    check(sb.size() == 0, "R8 missing results", 32'(sb.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule